// File: doc/BRIEF.md
# Synchronous FIFO with Mark and Retransmit

This block is a single-clock first-in first-out buffer of 36-bit words. Its depth is a power-of-two parameter. Master reset fixes one of two read timings, and that choice holds until the next master reset. In standard timing a word moves from storage to the data output only on a clock edge where the consumer asks for it. In fall-through timing the oldest stored word is presented on the output by itself, together with a valid indication, and a read request consumes that word.

A consumer can mark the location it is reading. A later retransmit request moves the read side back to that location, so a run of words can be delivered again. The write side is not affected. If no mark exists, the read side goes back to location zero. A synchronous partial clear empties the buffer and drops the mark but keeps the latched read timing. The block drives a head flag, a tail flag and a half-full flag. The meaning of the head and tail flags depends on the read timing.

Top module: `mark_fifo`

## Requirements
- R1: The read timing is copied from `fwft_sel` (0 = standard, 1 = fall-through) on clock edges while `rst_n` is low. Changes of `fwft_sel` while `rst_n` is high have no effect.
- R2: In standard timing, `rd_data` changes only on a clock edge where `rd_en` is high and the head flag shows data. Words come out in the order they were written.
- R3: In fall-through timing, a word written into an empty buffer on edge W is shown on `rd_data` with `head_flag` = 1 after edge W+2, with no `rd_en`. Every later word replaces the shown word only on an edge where `rd_en` consumes it.
- R4: `head_flag` is the empty indication (1 = no readable word) in standard timing. In fall-through timing it is output-ready (1 = `rd_data` holds an unread word).
- R5: `tail_flag` is full (1 = DEPTH words stored) in standard timing. In fall-through timing it is input-ready (1 = storage has space). A write while storage is full and a read while nothing is readable are both ignored.
- R6: `mark_req` on an edge records a mark position. In standard timing this is the next location to be read. In fall-through timing it is the location of the word shown on `rd_data` when one is shown.
- R7: `rt_req` on an edge moves reading back to the mark, or to location zero if no mark is held. Writes on that edge still take effect. A read or mark request on the same edge is ignored.
- R8: For the cycle after a retransmit edge, `head_flag` shows empty (standard) or not-ready (fall-through), and the read on the next edge is held off. Reading resumes on the following edge.
- R9: Master reset (`rst_n` low, asynchronous) empties the buffer, clears `rd_data` to zero and drops the mark.
- R10: `part_clr` high on an edge empties the buffer, clears `rd_data` to zero and drops the mark. It keeps the latched read timing. It overrides any write, read, mark or retransmit on that edge.
- R11: `half_flag` is 1 when occupancy is greater than DEPTH/2. Occupancy counts the stored words plus, in fall-through timing, the shown unread word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Master reset, asynchronous active low, released synchronously |
| part_clr | input | 1 | Synchronous partial clear |
| fwft_sel | input | 1 | Read timing choice, sampled during master reset |
| wr_en | input | 1 | Write request |
| wr_data | input | 36 | Write word |
| rd_en | input | 1 | Read request |
| mark_req | input | 1 | Record the current read location |
| rt_req | input | 1 | Rewind the read location to the mark |
| rd_data | output | 36 | Output word register |
| head_flag | output | 1 | Empty (standard) or output-ready (fall-through) |
| tail_flag | output | 1 | Full (standard) or input-ready (fall-through) |
| half_flag | output | 1 | Occupancy above half the depth |

## Verification
Both read timings are driven through the same patterns, and each pattern separates a different fault:
- a single word into an empty buffer, which shows the exact fall-through latency and the standard-mode need for a read request;
- a fill past full followed by a drain, which exposes lost or duplicated words and the threshold where the half flag switches;
- a mark followed by a retransmit, once with a mark held and once without, which separates a correct rewind target from a rewind to zero and shows the hold-off cycle.

Random mixes of reads, writes and marks are then checked on every clock against a behavioural model. The model keeps the full write history with absolute indices, which catches pointer wrap faults. A partial clear issued while a write is pending confirms that the clear wins and that the latched timing survives.

// File: rtl/mark_fifo_pkg.sv
package mark_fifo_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/mark_fifo_store.sv
module mark_fifo_store #(
  parameter int WIDTH = 36,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] cells [DEPTH];

  // one row per generate iteration, each with its own decoded enable
  for (genvar row = 0; row < DEPTH; row++) begin : g_row
    logic row_we;
    assign row_we = wr_en && (wr_addr == AW'(row));
    always_ff @(posedge clk) begin
      if (row_we) cells[row] <= wr_data;
    end
  end

  assign rd_data = cells[rd_addr];
endmodule

// File: rtl/mark_fifo_ptrs.sv
module mark_fifo_ptrs #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int PW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          part_clr,
  input  logic          fwft,
  input  logic          wr_req,
  input  logic          rd_pop,
  input  logic          mark_req,
  input  logic          rt_req,
  input  logic          head_vld,
  output logic          wr_do,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic [PW-1:0] mem_cnt,
  output logic          mem_full,
  output logic          fetch_ok
);
  localparam logic [PW-1:0] CNT_FULL = PW'(DEPTH);

  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d, seen_q, seen_d, mark_q, mark_d;
  logic          mark_v_q, mark_v_d, hold_q, hold_d, rt_go;

  assign mem_cnt  = wr_q - rd_q;
  assign mem_full = (mem_cnt == CNT_FULL);
  assign rt_go    = rt_req & ~part_clr;
  assign wr_do    = wr_req & ~mem_full & ~part_clr;
  // fall-through fetch looks at the write pointer one edge late
  assign fetch_ok = ~hold_q & (fwft ? (seen_q != rd_q) : (mem_cnt != '0));
  assign wr_addr  = wr_q[AW-1:0];
  assign rd_addr  = rd_q[AW-1:0];

  always_comb begin
    wr_d     = wr_q;
    rd_d     = rd_q;
    seen_d   = wr_q;
    mark_d   = mark_q;
    mark_v_d = mark_v_q;
    hold_d   = rt_go;
    if (part_clr) begin
      wr_d     = '0;
      rd_d     = '0;
      seen_d   = '0;
      mark_d   = '0;
      mark_v_d = 1'b0;
    end else begin
      if (wr_do) wr_d = wr_q + 1'b1;
      if (rt_go) rd_d = mark_v_q ? mark_q : '0;
      else if (rd_pop) rd_d = rd_q + 1'b1;
      if (mark_req && !rt_go) begin
        mark_v_d = 1'b1;
        mark_d   = rd_q - PW'(fwft & head_vld);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q     <= '0;
      rd_q     <= '0;
      seen_q   <= '0;
      mark_q   <= '0;
      mark_v_q <= 1'b0;
      hold_q   <= 1'b0;
    end else begin
      wr_q     <= wr_d;
      rd_q     <= rd_d;
      seen_q   <= seen_d;
      mark_q   <= mark_d;
      mark_v_q <= mark_v_d;
      hold_q   <= hold_d;
    end
  end
endmodule

// File: rtl/mark_fifo_head.sv
module mark_fifo_head #(
  parameter int WIDTH = 36
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             part_clr,
  input  logic             fwft,
  input  logic             rd_req,
  input  logic             rt_req,
  input  logic             fetch_ok,
  input  logic [WIDTH-1:0] mem_word,
  output logic             rd_pop,
  output logic [WIDTH-1:0] q,
  output logic             q_vld
);
  logic [WIDTH-1:0] q_q, q_d;
  logic             vld_q, vld_d, take;

  assign take   = fwft ? (~vld_q | rd_req) : rd_req;
  assign rd_pop = take & fetch_ok & ~rt_req & ~part_clr;
  assign q      = q_q;
  assign q_vld  = vld_q;

  always_comb begin
    q_d   = q_q;
    vld_d = vld_q;
    if (part_clr) begin
      q_d   = '0;
      vld_d = 1'b0;
    end else if (rt_req) begin
      vld_d = 1'b0;
    end else if (rd_pop) begin
      q_d   = mem_word;
      vld_d = fwft;
    end else if (rd_req) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q   <= '0;
      vld_q <= 1'b0;
    end else begin
      q_q   <= q_d;
      vld_q <= vld_d;
    end
  end
endmodule

// File: rtl/mark_fifo.sv
module mark_fifo
  import mark_fifo_pkg::*;
#(
  parameter int WIDTH = 36,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             part_clr,
  input  logic             fwft_sel,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic             mark_req,
  input  logic             rt_req,
  output logic [WIDTH-1:0] rd_data,
  output logic             head_flag,
  output logic             tail_flag,
  output logic             half_flag
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [PW:0] HALF_LVL = (PW+1)'(DEPTH / 2);

  rd_mode_e         mode_q;
  logic             mode_fwft;
  logic             wr_do, rd_pop, mem_full, fetch_ok, q_vld;
  logic [AW-1:0]    wr_addr, rd_addr;
  logic [PW-1:0]    mem_cnt;
  logic [PW:0]      occ;
  logic [WIDTH-1:0] mem_word;

  // timing choice is loaded only while master reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= rd_mode_e'(fwft_sel);
  end
  assign mode_fwft = (mode_q == MODE_FWFT);

  mark_fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) store_i (
    .clk(clk), .wr_en(wr_do), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(mem_word)
  );

  mark_fifo_ptrs #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) ptrs_i (
    .clk(clk), .rst_n(rst_n), .part_clr(part_clr), .fwft(mode_fwft),
    .wr_req(wr_en), .rd_pop(rd_pop), .mark_req(mark_req), .rt_req(rt_req),
    .head_vld(q_vld), .wr_do(wr_do), .wr_addr(wr_addr), .rd_addr(rd_addr),
    .mem_cnt(mem_cnt), .mem_full(mem_full), .fetch_ok(fetch_ok)
  );

  mark_fifo_head #(.WIDTH(WIDTH)) head_i (
    .clk(clk), .rst_n(rst_n), .part_clr(part_clr), .fwft(mode_fwft),
    .rd_req(rd_en), .rt_req(rt_req), .fetch_ok(fetch_ok), .mem_word(mem_word),
    .rd_pop(rd_pop), .q(rd_data), .q_vld(q_vld)
  );

  assign occ       = {1'b0, mem_cnt} + (PW+1)'(mode_fwft & q_vld);
  assign head_flag = mode_fwft ? q_vld : ~fetch_ok;
  assign tail_flag = mode_fwft ? ~mem_full : mem_full;
  assign half_flag = (occ > HALF_LVL);
endmodule

// File: rtl/mark_fifo_chk.sv
module mark_fifo_chk #(
  parameter int WIDTH = 36,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int PW    = AW + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             part_clr,
  input logic             rd_en,
  input logic             rt_req,
  input logic             fwft,
  input logic [WIDTH-1:0] rd_data,
  input logic             head_flag,
  input logic             tail_flag,
  input logic [PW-1:0]    mem_cnt,
  input logic [AW-1:0]    wr_addr
);
  AST_MODE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(fwft)); // R1
  AST_STD_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fwft && !rd_en && !part_clr) |=> $stable(rd_data)); // R2
  AST_EMPTY_READ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!fwft && head_flag && !part_clr) |=> $stable(rd_data)); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cnt <= PW'(DEPTH)); // R5
  AST_FULL_WPTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((fwft ? !tail_flag : tail_flag) && !part_clr) |=> (wr_addr == $past(wr_addr))); // R5
  AST_RT_FLAG_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_req && !part_clr) |=> (fwft ? !head_flag : head_flag)); // R8
  AST_PCLR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    part_clr |=> ((rd_data == '0) && (fwft ? !head_flag : head_flag))); // R10
endmodule

bind mark_fifo mark_fifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .part_clr(part_clr), .rd_en(rd_en), .rt_req(rt_req),
  .fwft(mode_fwft), .rd_data(rd_data), .head_flag(head_flag), .tail_flag(tail_flag),
  .mem_cnt(mem_cnt), .wr_addr(wr_addr)
);

// File: tb/mark_fifo_tb_top.sv
module mark_fifo_tb_top;
  localparam int W = 36;
  localparam int D = 16;

  logic clk, rst_n, part_clr, fwft_sel, wr_en, rd_en, mark_req, rt_req;
  logic [W-1:0] wr_data, rd_data;
  logic head_flag, tail_flag, half_flag;

  int n_chk = 0;
  int n_err = 0;

  // behavioural reference: absolute indices into a write history
  logic [W-1:0] hist [1024];
  int wr_n, rd_n, seen_n, mark_n;
  bit mark_v, hold, qv, fw;
  logic [W-1:0] q_m;

  mark_fifo #(.WIDTH(W), .DEPTH(D)) dut_i (
    .clk(clk), .rst_n(rst_n), .part_clr(part_clr), .fwft_sel(fwft_sel),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .mark_req(mark_req),
    .rt_req(rt_req), .rd_data(rd_data), .head_flag(head_flag),
    .tail_flag(tail_flag), .half_flag(half_flag)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    wr_n = 0; rd_n = 0; seen_n = 0; mark_n = 0;
    mark_v = 0; hold = 0; qv = 0; q_m = '0;
  endtask

  task automatic model_edge(input bit w, input logic [W-1:0] d, input bit r,
                            input bit mk, input bit rt, input bit pc);
    int cnt;
    int new_mark;
    bit full, avail, pop;
    if (pc) begin
      model_clear();
      return;
    end
    cnt = wr_n - rd_n;
    full = (cnt == D);
    avail = !hold && (fw ? (seen_n != rd_n) : (cnt != 0));
    pop = avail && !rt && (fw ? (!qv || r) : r);
    new_mark = rd_n - ((fw && qv) ? 1 : 0);
    seen_n = wr_n;
    if (w && !full) begin
      hist[wr_n % 1024] = d;
      wr_n++;
    end
    if (rt) begin
      rd_n = mark_v ? mark_n : 0;
      qv = 0;
    end else if (pop) begin
      q_m = hist[rd_n % 1024];
      rd_n++;
      qv = fw;
    end else if (r) begin
      qv = 0;
    end
    if (mk && !rt) begin
      mark_n = new_mark;
      mark_v = 1;
    end
    hold = rt;
  endtask

  task automatic compare();
    int cnt;
    bit full;
    cnt = wr_n - rd_n;
    full = (cnt == D);
    chk(fw ? "R3 data" : "R2 data", rd_data, q_m);
    chk("R4 head flag", W'(head_flag), W'(fw ? qv : (cnt == 0 || hold)));
    chk("R5 tail flag", W'(tail_flag), W'(fw ? !full : full));
    chk("R11 half flag", W'(half_flag), W'((cnt + ((fw && qv) ? 1 : 0)) > D / 2));
  endtask

  task automatic step(input bit w, input logic [W-1:0] d, input bit r,
                      input bit mk, input bit rt, input bit pc);
    wr_en = w; wr_data = d; rd_en = r; mark_req = mk; rt_req = rt; part_clr = pc;
    @(posedge clk);
    model_edge(w, d, r, mk, rt, pc);
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    step(0, '0, 0, 0, 0, 0);
  endtask

  task automatic master_reset(input bit m);
    rst_n = 1'b0; fwft_sel = m;
    wr_en = 0; wr_data = '0; rd_en = 0; mark_req = 0; rt_req = 0; part_clr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_clear();
    fw = m;
    compare();
    fwft_sel = !m; // R1: must be ignored from here on
  endtask

  function automatic logic [W-1:0] word(input int i);
    return W'(64'h9_0000_0000) ^ W'(i * 32'h0101_0307);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    // ---------------- standard timing ----------------
    master_reset(0);
    chk("R9 reset data", rd_data, '0);
    chk("R9 reset empty", W'(head_flag), W'(1));
    step(0, '0, 1, 0, 0, 0);
    chk("R5 read of empty ignored", rd_data, '0);
    for (int i = 0; i < 5; i++) step(1, word(i), 0, 0, 0, 0);
    idle();
    chk("R2 no read keeps output", rd_data, '0);
    step(0, '0, 1, 0, 0, 0);
    chk("R2 first word", rd_data, word(0));
    step(0, '0, 1, 1, 0, 0);
    chk("R6 marked read", rd_data, word(1));
    step(0, '0, 1, 0, 0, 0);
    step(0, '0, 1, 0, 0, 0);
    chk("R2 fourth word", rd_data, word(3));
    step(0, '0, 1, 0, 1, 0);
    chk("R8 empty forced", W'(head_flag), W'(1));
    chk("R7 read ignored on rewind", rd_data, word(3));
    step(0, '0, 1, 0, 0, 0);
    chk("R8 read held off", rd_data, word(3));
    step(0, '0, 1, 0, 0, 0);
    chk("R7 rewind to mark", rd_data, word(1));
    while (!head_flag) step(0, '0, 1, 0, 0, 0);
    for (int i = 1; i <= D; i++) begin
      step(1, word(100 + i), 0, 0, 0, 0);
      chk("R11 half threshold", W'(half_flag), W'(i > D / 2));
    end
    chk("R5 full", W'(tail_flag), W'(1));
    step(1, word(999), 0, 0, 0, 0);
    while (!head_flag) step(0, '0, 1, 0, 0, 0);
    chk("R5 write to full dropped", rd_data, word(100 + D));
    step(1, word(7), 0, 0, 0, 1);
    chk("R10 clear data", rd_data, '0);
    chk("R10 clear empty", W'(head_flag), W'(1));
    for (int i = 0; i < 4; i++) step(1, word(200 + i), 0, 0, 0, 0);
    step(0, '0, 1, 0, 0, 0);
    step(0, '0, 1, 0, 0, 0);
    step(0, '0, 0, 0, 1, 0);
    idle();
    step(0, '0, 1, 0, 0, 0);
    chk("R7 rewind without mark", rd_data, word(200));
    for (int i = 0; i < 250; i++)
      step(($urandom % 3) != 0, word(300 + i), ($urandom % 2) == 1, ($urandom % 16) == 0, 0, 0);

    // ---------------- fall-through timing ----------------
    master_reset(1);
    step(1, word(500), 0, 0, 0, 0);
    chk("R3 not yet shown", W'(head_flag), W'(0));
    idle();
    chk("R3 latency edge one", W'(head_flag), W'(0));
    idle();
    chk("R3 shown after two edges", rd_data, word(500));
    chk("R1 mode kept", W'(head_flag), W'(1));
    step(1, word(501), 0, 0, 0, 0);
    step(1, word(502), 0, 0, 0, 0);
    idle(); idle(); idle();
    chk("R3 later word waits", rd_data, word(500));
    step(0, '0, 1, 0, 0, 0);
    chk("R3 consume", rd_data, word(501));
    step(0, '0, 0, 1, 0, 0);
    step(0, '0, 1, 0, 0, 0);
    chk("R3 next", rd_data, word(502));
    step(0, '0, 0, 0, 1, 0);
    chk("R8 not ready", W'(head_flag), W'(0));
    idle();
    chk("R8 hold cycle", W'(head_flag), W'(0));
    idle();
    chk("R6 shown word marked", rd_data, word(501));
    chk("R7 ready again", W'(head_flag), W'(1));
    for (int i = 0; i < D + 3; i++) step(1, word(600 + i), 0, 0, 0, 0);
    chk("R5 input not ready", W'(tail_flag), W'(0));
    step(1, word(7), 0, 0, 0, 1);
    chk("R10 clear data fwft", rd_data, '0);
    step(1, word(700), 0, 0, 0, 0);
    idle(); idle();
    chk("R10 mode kept", rd_data, word(700));
    for (int i = 0; i < 250; i++)
      step(($urandom % 3) != 0, word(800 + i), ($urandom % 2) == 1, ($urandom % 16) == 0, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule